// File: doc/BRIEF.md
# Numerically Controlled Oscillator Core

This block is the digital heart of a direct digital synthesizer. On every system clock it advances a 32-bit phase register by a programmable tuning word, so the output frequency is `tuning_word × f_clk / 2^32`. A 14-bit phase offset is added on top of the running phase. The sum is cut down to 19 bits and turned into a 14-bit two's-complement cosine sample by a quarter-wave table with quadrant folding. The sample is then multiplied by an amplitude factor and presented as the word for an external converter.

A clear input returns the phase register to zero, which lets a host restart the waveform at a known phase. The block also divides the system clock by four to give a sync clock that neighbouring logic can use to launch control changes. The word from the clear input or the phase register to the converter has a fixed latency of three clocks, counted from the edge where the phase register changes.

Top module: `dds_nco_core`

## Requirements
- R1: On each clock that `acc_clear` is low, the phase register becomes its old value plus `tuning_word`, modulo 2^32.
- R2: A clock edge with `acc_clear` high sets the phase register to zero, whatever `tuning_word` is.
- R3: The lookup phase is the top 19 bits of (phase register + `phase_offset` × 2^18) modulo 2^32. The table index k is the top 10 bits of those 19.
- R4: The cosine sample for index k is round(8191 × cos(2π(k+0.5)/1024)) within ±1, in two's complement, and its magnitude never exceeds 8191.
- R5: `dac_word` = floor(c × a / 16384), where c is the cosine sample and a is `amp_scale`. Any `amp_scale` above 16384 acts as 16384 (unity gain), and `amp_scale` = 0 gives 0.
- R6: A phase register value set at edge e reaches the lookup stage at edge e+1 with the `phase_offset` sampled there. It becomes a cosine sample at e+2 and appears on `dac_word`, scaled by the `amp_scale` sampled at e+3, after edge e+3.
- R7: `sync_clk` is low after reset. It then alternates between two clocks low and two clocks high, a period of four system clocks.
- R8: While `rst` is high, the phase register, every pipeline stage and `dac_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tuning_word | input | 32 | Phase increment per clock |
| phase_offset | input | 14 | Phase offset, weight 2^18 on the 32-bit phase |
| amp_scale | input | 15 | Amplitude factor, 16384 = unity |
| acc_clear | input | 1 | Clears the phase register at the next edge |
| dac_word | output | 14 | Two's-complement scaled cosine sample |
| sync_clk | output | 1 | System clock divided by four |

## Verification
A tuning word of zero combined with a series of offset steps walks the table through each quadrant boundary. This separates the folding and sign logic from the accumulator. A tuning word of all ones makes the phase register step backwards through its wrap, which shows whether the modulo addition is correct. Random tuning words, offsets and amplitude factors drawn every clock cover the whole table and the full scaling range. Zero, unity and above-unity amplitude factors expose errors in the clamp and in the rounding direction of the scaling.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        QUAD_I   = 2'd0,
        QUAD_II  = 2'd1,
        QUAD_III = 2'd2,
        QUAD_IV  = 2'd3
    } quad_e;

    typedef struct packed {
        quad_e quad;
        logic  mirror;
        logic  negate;
    } fold_t;

    function automatic fold_t fold_of(input quad_e q);
        fold_t f;
        f.quad   = q;
        f.mirror = (q == QUAD_II) || (q == QUAD_IV);
        f.negate = (q == QUAD_II) || (q == QUAD_III);
        return f;
    endfunction

    localparam real TWO_PI = 6.283185307179586;

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int ACC_W   = 32,
    parameter int OFF_W   = 14,
    parameter int TRUNC_W = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ACC_W-1:0]   tuning_word,
    input  logic [OFF_W-1:0]   phase_offset,
    input  logic               acc_clear,
    output logic [TRUNC_W-1:0] phase_q
);
    localparam int OFF_SHIFT = ACC_W - OFF_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] phase_sum;

    assign phase_sum = acc_q + {phase_offset, {OFF_SHIFT{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            phase_q <= '0;
        end else begin
            acc_q   <= acc_clear ? '0 : acc_q + tuning_word;
            phase_q <= phase_sum[ACC_W-1 -: TRUNC_W];
        end
    end

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(acc_clear) && !$past(rst) |-> acc_q == '0); // R2
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(acc_clear) && !$past(rst) |-> acc_q == $past(acc_q) + $past(tuning_word)); // R1

endmodule

// File: rtl/dds_cos_lut.sv
module dds_cos_lut
    import dds_pkg::*;
#(
    parameter int LUT_AW = 10,
    parameter int OUT_W  = 14
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LUT_AW-1:0]       index,
    output logic signed [OUT_W-1:0] cos_q
);
    localparam int QA    = LUT_AW - 2;
    localparam int DEPTH = 2 ** QA;
    localparam int PEAK  = 2 ** (OUT_W - 1) - 1;
    localparam int FULL  = 2 ** LUT_AW;

    logic [OUT_W-2:0] rom [DEPTH];

    function automatic int quarter_mag(input int i);
        real v;
        v = real'(PEAK) * $cos(TWO_PI * (real'(i) + 0.5) / real'(FULL));
        return $rtoi(v + 0.5);
    endfunction

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            rom[i] = (OUT_W-1)'(quarter_mag(i));
        end
    end

    fold_t            fld;
    logic [QA-1:0]    addr;
    logic [OUT_W-1:0] mag;

    always_comb begin
        fld  = fold_of(quad_e'(index[LUT_AW-1 -: 2]));
        addr = fld.mirror ? ~index[QA-1:0] : index[QA-1:0];
        mag  = {1'b0, rom[addr]};
    end

    always_ff @(posedge clk) begin
        if (rst) cos_q <= '0;
        else     cos_q <= fld.negate ? -$signed(mag) : $signed(mag);
    end

    AST_COS_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cos_q <= PEAK) && (cos_q >= -PEAK)); // R4

endmodule

// File: rtl/dds_amp_scale.sv
module dds_amp_scale #(
    parameter int OUT_W = 14,
    parameter int ASF_W = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [OUT_W-1:0] cos_in,
    input  logic [ASF_W-1:0]        amp_scale,
    output logic signed [OUT_W-1:0] dac_word
);
    localparam int               SHIFT = ASF_W - 1;
    localparam logic [ASF_W-1:0] UNITY = ASF_W'(1) << SHIFT;
    localparam int               PW    = OUT_W + ASF_W + 1;

    logic [ASF_W-1:0]     asf_c;
    logic signed [PW-1:0] prod;

    always_comb begin
        asf_c = (amp_scale > UNITY) ? UNITY : amp_scale;
        prod  = PW'(cos_in) * $signed({1'b0, asf_c});
    end

    always_ff @(posedge clk) begin
        if (rst) dac_word <= '0;
        else     dac_word <= prod[SHIFT +: OUT_W];
    end

    AST_AMP_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(amp_scale) == '0 && !$past(rst) |-> dac_word == '0); // R5
    AST_AMP_UNITY: assert property (@(posedge clk) disable iff (rst)
        $past(amp_scale) >= UNITY && !$past(rst) |-> dac_word == $past(cos_in)); // R5

endmodule

// File: rtl/dds_sync_div.sv
module dds_sync_div (
    input  logic clk,
    input  logic rst,
    output logic sync_clk
);
    logic [1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 2'd1;
    end

    assign sync_clk = cnt_q[1];

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(sync_clk) != $past(sync_clk, 2)) |-> sync_clk == $past(sync_clk)); // R7

endmodule

// File: rtl/dds_nco_core.sv
module dds_nco_core #(
    parameter int ACC_W   = 32,
    parameter int OFF_W   = 14,
    parameter int TRUNC_W = 19,
    parameter int LUT_AW  = 10,
    parameter int OUT_W   = 14,
    parameter int ASF_W   = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W-1:0]        tuning_word,
    input  logic [OFF_W-1:0]        phase_offset,
    input  logic [ASF_W-1:0]        amp_scale,
    input  logic                    acc_clear,
    output logic signed [OUT_W-1:0] dac_word,
    output logic                    sync_clk
);
    logic [TRUNC_W-1:0]      phase_q;
    logic signed [OUT_W-1:0] cos_q;

    dds_phase_acc #(.ACC_W(ACC_W), .OFF_W(OFF_W), .TRUNC_W(TRUNC_W)) u_acc (
        .clk(clk), .rst(rst), .tuning_word(tuning_word),
        .phase_offset(phase_offset), .acc_clear(acc_clear), .phase_q(phase_q)
    );

    dds_cos_lut #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_lut (
        .clk(clk), .rst(rst), .index(phase_q[TRUNC_W-1 -: LUT_AW]), .cos_q(cos_q)
    );

    dds_amp_scale #(.OUT_W(OUT_W), .ASF_W(ASF_W)) u_amp (
        .clk(clk), .rst(rst), .cos_in(cos_q), .amp_scale(amp_scale), .dac_word(dac_word)
    );

    dds_sync_div u_sync (.clk(clk), .rst(rst), .sync_clk(sync_clk));

    AST_RESET_OUT: assert property (@(posedge clk)
        $past(rst) |-> dac_word == '0); // R8

endmodule

// File: tb/dds_nco_core_tb.sv
module dds_nco_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tuning_word = '0;
    logic [13:0] phase_offset = '0;
    logic [14:0] amp_scale = 15'd16384;
    logic        acc_clear = 1'b0;
    logic signed [13:0] dac_word;
    logic        sync_clk;

    always #4 clk = ~clk;

    dds_nco_core dut_i (
        .clk(clk), .rst(rst), .tuning_word(tuning_word), .phase_offset(phase_offset),
        .amp_scale(amp_scale), .acc_clear(acc_clear), .dac_word(dac_word), .sync_clk(sync_clk)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] m_acc;
    int          m_idx;
    int          m_cos;
    int          m_out;
    int          edges;

    function automatic int ref_cos(input int k);
        real v;
        v = 8191.0 * $cos(6.283185307179586 * (real'(k) + 0.5) / 1024.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int ref_scale(input int c, input int a);
        longint p;
        int     ac;
        ac = (a > 16384) ? 16384 : a;
        p  = longint'(c) * longint'(ac);
        return int'(p >>> 14);
    endfunction

    function automatic int ref_index(input logic [31:0] acc, input logic [13:0] off);
        logic [31:0] s;
        s = acc + {off, 18'b0};
        return int'(s[31:22]);
    endfunction

    task automatic check(input string req, input int act, input int exp, input int tol);
        int d;
        n_vec++;
        d = act - exp;
        if (d > tol || d < -tol) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        m_out = ref_scale(m_cos, int'(amp_scale));
        m_cos = ref_cos(m_idx);
        m_idx = ref_index(m_acc, phase_offset);
        m_acc = acc_clear ? 32'd0 : m_acc + tuning_word;
        edges++;
        @(negedge clk);
        check(req, int'(dac_word), m_out, 1);
        check("R7", int'(sync_clk), (edges >> 1) & 1, 0);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0011));
        m_acc = 0; m_idx = 0; m_cos = 0; m_out = 0; edges = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", int'(dac_word), 0, 0);
        check("R8", int'(sync_clk), 0, 0);
        rst = 1'b0;

        // R3 R4: walk quadrant boundaries with a frozen phase
        acc_clear = 1'b1; tick("R2");
        acc_clear = 1'b0;
        for (int q = 0; q < 16; q++) begin
            phase_offset = 14'(q * 1024 - 16);
            repeat (4) tick("R4");
            phase_offset = 14'(q * 1024 + 16);
            repeat (4) tick("R3");
        end

        // R5: zero, unity, above unity and half scale
        amp_scale = 15'd0;     repeat (4) tick("R5");
        amp_scale = 15'd32767; repeat (4) tick("R5");
        amp_scale = 15'd8192;  repeat (4) tick("R5");
        amp_scale = 15'd16384;

        // R1: backwards wrap with all-ones tuning word
        phase_offset = 14'd0;
        tuning_word = 32'hFFFF_FFFF;
        repeat (8) tick("R1");
        tuning_word = 32'h0123_4567;
        repeat (200) tick("R1");

        // R2 R6: clear during a run, offset change lands at fixed latency
        acc_clear = 1'b1; tick("R2");
        acc_clear = 1'b0; tuning_word = 32'd0; phase_offset = 14'h2000;
        repeat (4) tick("R6");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            tuning_word  = $urandom;
            phase_offset = 14'($urandom);
            amp_scale    = 15'($urandom);
            acc_clear    = ($urandom % 32) == 0;
            tick("R6");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule